// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

The block holds two independent down-counting channels, 32 bits wide by default. Each channel has a reload register and a live count register. One shared control word holds a run bit and a repeat bit for each channel. An enabled channel decrements on every clock. When it leaves zero, the channel expires. In repeat mode it then refills from its reload register. In single-shot mode it parks at zero and produces no further events until software writes a new count. Every expiry sets a pending bit in a cause register. A mask register decides which pending bits reach the single interrupt output.

Software reaches all registers through a one-cycle register port. A write is taken on the clock edge where the write strobe is high. Read data is registered, so it shows the addressed register as it stood just before the following edge. A common use is to run one channel unmasked as a free-running timestamp: it is reloaded from all ones and read back inverted. The other channel serves as an interrupt-driven event timer.

Top module: `dual_dntimer`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: The control word is at byte offset 0x000. Channel c has its run bit at position 2c and its repeat bit at position 2c+1. All four bits read back as written, and upper bits read 0.
- R3: A running channel's count drops by exactly one per clock. The count registers are at offset 0x014 (channel 0) and 0x01C (channel 1), and they can be read while counting. With a count preloaded to all ones, its inverted value increases by one per clock.
- R4: In repeat mode, writing N-1 to both the reload register (0x010 for channel 0, 0x018 for channel 1) and the count register gives the count sequence N-1 down to 0, then N-1 again. The channel expires every N clocks.
- R5: In single-shot mode, a channel with a loaded value V expires once, V+1 clocks after it starts, and then holds 0. Its pending bit does not come back after it is cleared, until the count register is written again.
- R6: Clearing a channel's run bit freezes its count.
- R7: A write to a count register sets the count on that edge. It overrides a decrement, a reload or an expiry that would have happened on the same edge.
- R8: The cause register is at 0x110. Channel c expiring sets cause bit c+1. Writing a 0 to a bit clears it and writing a 1 leaves it unchanged. If an expiry and a clear fall on the same edge, the bit ends up set.
- R9: The mask register is at 0x114. `irq_o` is the OR of cause AND mask, registered, so it follows one clock later. A masked channel still counts and still sets its cause bit.
- R10: Cause and mask bit 0 and all bits above bit 2 read 0. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W (9) | Byte offset of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data for the address presented before the edge |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach are the same-edge collisions. One is a cause-clear write landing on the exact edge where a channel expires. The other is a count write landing on the edge where a repeating channel would have reloaded. The bench gets there by starting the channel from a known small count and counting the clocks from the enabling write. It then issues the colliding write so that it is taken on the computed expiry edge. Single-shot and repeat modes are swept over several short periods on both channels, and each read of the count register is compared with an arithmetically derived value.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int NCH  = 2;
  localparam int CB_W = NCH + 1;

  localparam logic [8:0] A_CTRL  = 9'h000;
  localparam logic [8:0] A_RLD0  = 9'h010;
  localparam logic [8:0] A_VAL0  = 9'h014;
  localparam logic [8:0] A_CAUSE = 9'h110;
  localparam logic [8:0] A_MASK  = 9'h114;
  localparam logic [8:0] A_STEP  = 9'h008;

  function automatic logic [8:0] rld_addr(input int c);
    return A_RLD0 + A_STEP * 9'(c);
  endfunction

  function automatic logic [8:0] val_addr(input int c);
    return A_VAL0 + A_STEP * 9'(c);
  endfunction
endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run_i,
  input  logic         repeat_i,
  input  logic         rld_we_i,
  input  logic         val_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rld_o,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] rld_q, cnt_q;
  logic         spent_q;

  assign expire_o = run_i && (cnt_q == '0) && (repeat_i || !spent_q) && !val_we_i;
  assign rld_o    = rld_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rld_q   <= '0;
      cnt_q   <= '0;
      spent_q <= 1'b0;
    end else begin
      if (rld_we_i) rld_q <= wdata_i;
      if (val_we_i) begin
        cnt_q   <= wdata_i;
        spent_q <= 1'b0;
      end else if (expire_o) begin
        if (repeat_i) begin
          cnt_q   <= rld_q;
          spent_q <= 1'b0;
        end else begin
          spent_q <= 1'b1;
        end
      end else if (run_i && cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end
endmodule

// File: rtl/dtmr_irq.sv
module dtmr_irq #(
  parameter int          NB   = 3,
  parameter logic [NB-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cause_we_i,
  input  logic          mask_we_i,
  input  logic [NB-1:0] wdata_i,
  input  logic [NB-1:0] set_i,
  output logic [NB-1:0] cause_o,
  output logic [NB-1:0] mask_o,
  output logic          irq_o
);
  logic [NB-1:0] cause_q, mask_q, cause_kept;
  logic          irq_q;

  assign cause_kept = cause_we_i ? (cause_q & wdata_i) : cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= (cause_kept | set_i) & IMPL;
      if (mask_we_i) mask_q <= wdata_i & IMPL;
      irq_q <= |(cause_q & mask_q);
    end
  end

  assign cause_o = cause_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  import dtmr_pkg::*;

  localparam int CTRL_W = 2 * NCH;
  localparam logic [CB_W-1:0] IMPL_BITS = {{NCH{1'b1}}, 1'b0};

  logic [CTRL_W-1:0]           ctrl_q;
  logic [NCH-1:0]              run_w, rep_w, rld_we_w, val_we_w, exp_w;
  logic [NCH-1:0][CNT_W-1:0]   rld_w, cnt_w;
  logic [CB_W-1:0]             cause_w, mask_w;
  logic [CNT_W-1:0]            rd_mux, rdata_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_we && bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign run_w[c]    = ctrl_q[2*c];
    assign rep_w[c]    = ctrl_q[2*c+1];
    assign rld_we_w[c] = bus_we && (bus_addr == ADDR_W'(rld_addr(c)));
    assign val_we_w[c] = bus_we && (bus_addr == ADDR_W'(val_addr(c)));

    dtmr_chan #(.W(CNT_W)) chan_i (
      .clk      (clk),
      .rst      (rst),
      .run_i    (run_w[c]),
      .repeat_i (rep_w[c]),
      .rld_we_i (rld_we_w[c]),
      .val_we_i (val_we_w[c]),
      .wdata_i  (bus_wdata),
      .rld_o    (rld_w[c]),
      .cnt_o    (cnt_w[c]),
      .expire_o (exp_w[c])
    );
  end

  dtmr_irq #(.NB(CB_W), .IMPL(IMPL_BITS)) irq_i (
    .clk        (clk),
    .rst        (rst),
    .cause_we_i (bus_we && bus_addr == ADDR_W'(A_CAUSE)),
    .mask_we_i  (bus_we && bus_addr == ADDR_W'(A_MASK)),
    .wdata_i    (bus_wdata[CB_W-1:0]),
    .set_i      ({exp_w, 1'b0}),
    .cause_o    (cause_w),
    .mask_o     (mask_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL))  rd_mux = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(A_CAUSE)) rd_mux = CNT_W'(cause_w);
    if (bus_addr == ADDR_W'(A_MASK))  rd_mux = CNT_W'(mask_w);
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(rld_addr(c))) rd_mux = rld_w[c];
      if (bus_addr == ADDR_W'(val_addr(c))) rd_mux = cnt_w[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic [W-1:0]         wdata,
  input logic [NCH-1:0]       run,
  input logic [NCH-1:0]       rep,
  input logic [NCH-1:0]       vwe,
  input logic [NCH-1:0][W-1:0] cnt,
  input logic [NCH-1:0]       expire,
  input logic [NCH:0]         cause,
  input logic [NCH:0]         mask,
  input logic                 irq
);
  localparam logic [W-1:0] ONE = W'(1);

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (run[c] && cnt[c] != '0 && !vwe[c]) |=> (cnt[c] + ONE == $past(cnt[c]))); // R3
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
      (!run[c] && !vwe[c]) |=> $stable(cnt[c])); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
      vwe[c] |=> (cnt[c] == $past(wdata))); // R7
    AST_PARK_ZERO: assert property (@(posedge clk) disable iff (rst)
      (run[c] && !rep[c] && cnt[c] == '0 && !vwe[c]) |=> (cnt[c] == '0)); // R5
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (rst)
      expire[c] |=> cause[c+1]); // R8
  end

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(cause & mask)))); // R9
endmodule

bind dual_dntimer dtmr_chk #(.W(CNT_W), .NCH(dtmr_pkg::NCH)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .wdata  (bus_wdata),
  .run    (run_w),
  .rep    (rep_w),
  .vwe    (val_we_w),
  .cnt    (cnt_w),
  .expire (exp_w),
  .cause  (cause_w),
  .mask   (mask_w),
  .irq    (irq_o)
);

// File: tb/dual_dntimer_tb.sv
module dual_dntimer_tb_top;
  localparam logic [8:0] CTRL = 9'h000, CAUSE = 9'h110, MASK = 9'h114;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_dntimer dut_i (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [8:0] rld_a(input int c); return 9'h010 + 9'(8 * c); endfunction
  function automatic logic [8:0] val_a(input int c); return 9'h014 + 9'(8 * c); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of all registers and the interrupt
    check("R1 irq", 32'(irq), 0);
    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(CAUSE, v); check("R1 cause", v, 0);
    rd(MASK, v);  check("R1 mask", v, 0);
    for (int c = 0; c < 2; c++) begin
      rd(rld_a(c), v); check("R1 reload", v, 0);
      rd(val_a(c), v); check("R1 count", v, 0);
    end

    // R2: control word readback sweep
    for (int k = 0; k < 16; k++) begin
      wr(CTRL, 32'hFFFF_FFF0 | 32'(k));
      rd(CTRL, v); check("R2 ctrl", v, 32'(k));
    end
    wr(CTRL, 0); wr(CAUSE, 0);

    // R3 R5 R8 R9: single-shot sweep on both channels
    for (int c = 0; c < 2; c++) begin
      for (int n = 1; n <= 6; n++) begin
        wr(CTRL, 0); wr(CAUSE, 0); wr(MASK, 32'(1) << (c + 1));
        wr(val_a(c), 32'(n - 1));
        wr(CTRL, 32'(1) << (2 * c));
        addr = val_a(c);
        for (int j = 0; j < n + 3; j++) begin
          @(negedge clk);
          check("R3 single-shot count", rdata, (n - 1 - j > 0) ? 32'(n - 1 - j) : 0);
        end
        check("R9 irq raised", 32'(irq), 1);
        rd(CAUSE, v); check("R8 cause position", v, 32'(1) << (c + 1));
        wr(CAUSE, 0);
        repeat (10) @(negedge clk);
        rd(CAUSE, v); check("R5 no second expiry", v, 0);
        rd(val_a(c), v); check("R5 parked at zero", v, 0);
        check("R9 irq cleared", 32'(irq), 0);
      end
    end

    // R4: repeat mode period sweep
    for (int c = 0; c < 2; c++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(CTRL, 0); wr(CAUSE, 0);
        wr(rld_a(c), 32'(n - 1)); wr(val_a(c), 32'(n - 1));
        wr(CTRL, 32'(3) << (2 * c));
        addr = val_a(c);
        for (int j = 0; j < 3 * n; j++) begin
          @(negedge clk);
          check("R4 periodic count", rdata, 32'((((n - 1 - j) % n) + n) % n));
        end
        rd(CAUSE, v); check("R4 cause set", v, 32'(1) << (c + 1));
      end
    end

    // R3 free-running timestamp, R9 masked channel gives no interrupt
    wr(CTRL, 0); wr(MASK, 0); wr(CAUSE, 0);
    wr(rld_a(0), 32'hFFFF_FFFF); wr(val_a(0), 32'hFFFF_FFFF);
    wr(CTRL, 3);
    addr = val_a(0);
    @(negedge clk); v = rdata;
    @(negedge clk); v2 = rdata;
    check("R3 timestamp start", ~v, 0);
    check("R3 timestamp step", ~v2, 1);
    check("R9 masked irq low", 32'(irq), 0);

    // R6: stopping freezes the count
    wr(CTRL, 0);
    rd(val_a(0), v); rd(val_a(0), v2);
    check("R6 frozen count", v2, v);
    repeat (5) @(negedge clk);
    rd(val_a(0), v2); check("R6 still frozen", v2, v);

    // R7: count write on the reload edge wins
    wr(CAUSE, 0); wr(rld_a(0), 9); wr(val_a(0), 3);
    wr(CTRL, 3);
    repeat (3) @(negedge clk);
    wr(val_a(0), 7);
    rd(val_a(0), v); check("R7 write overrides reload", v, 7);
    rd(CAUSE, v);    check("R7 no expiry on write edge", v, 0);
    rd(val_a(0), v); check("R7 counting resumes", v, 5);

    // R8: set wins over a same-edge clear, write-zero-to-clear
    wr(CTRL, 0); wr(CAUSE, 0);
    wr(val_a(1), 2); wr(CTRL, 4);
    repeat (2) @(negedge clk);
    wr(CAUSE, 0);
    rd(CAUSE, v); check("R8 set beats clear", v, 4);
    wr(CAUSE, 32'hFFFF_FFFF);
    rd(CAUSE, v); check("R8 ones keep bit", v, 4);
    wr(CAUSE, ~32'h4);
    rd(CAUSE, v); check("R8 zero clears bit", v, 0);

    // R9: masked expiry sets cause; irq follows mask one clock late
    wr(MASK, 0); wr(val_a(1), 0);
    repeat (3) @(negedge clk);
    check("R9 masked irq", 32'(irq), 0);
    rd(CAUSE, v); check("R9 masked cause set", v, 4);
    wr(MASK, 4);
    check("R9 irq lag", 32'(irq), 0);
    @(negedge clk);
    check("R9 irq after mask", 32'(irq), 1);

    // R10: unimplemented bits and offsets
    wr(MASK, 32'hFFFF_FFFF);
    rd(MASK, v); check("R10 mask bits", v, 6);
    rd(9'h004, v); check("R10 unmapped 0x004", v, 0);
    rd(9'h100, v); check("R10 unmapped 0x100", v, 0);

    finish_run();
  end
endmodule